// File: doc/BRIEF.md
# Page Load and Program Controller

This block takes over once a page program command has been accepted. It collects up to one page of words from chip-enable write pulses. The address of each pulse is taken when chip enable is first seen low, and the data when it is first seen high again. Words may come in any order inside one page. A gap timer ends loading after the chip-enable line has been idle for a set number of cycles. The block then writes every word it received to the array write port and waits out a programming period. It finishes by reporting done, or done with fail.

The page is fixed by the first word that is accepted. Every word keeps its own valid flag, so only loaded offsets reach the array. A chip-enable low pulse that is too short counts as a glitch and loads nothing. A failure stays recorded until it is cleared, and a new program cannot start while it is recorded. All timing is counted in clock cycles set by parameters. Chip enable is a synchronous, active-low input that is sampled on every rising clock edge.

Top module: `page_prog_ctrl`

## Requirements
- R1: After reset, busy, loading, done, fail and arr_we are all 0.
- R2: When idle with fail clear, a start pulse sets loading and busy on the next clock and clears done. The same pulse clears every word valid flag, so words from an earlier load are never written again.
- R3: The address of a word is captured on the first clock where ce_n is sampled 0. The data is captured on the first clock where ce_n is sampled 1 again. A word is accepted only if ce_n was sampled low on at least GLITCH_CYC clocks. A shorter pulse is ignored.
- R4: Address bits [5:0] give the word offset inside the page (WORDS=64) and the bits above them give the page. Words may be loaded in any order. When the same offset is loaded twice, the last data is kept.
- R5: The page of the first accepted word becomes the page of the load. An accepted word whose page bits differ is ignored.
- R6: Loading ends when ce_n has been sampled 1 on GAP_CYC clocks in a row. The count restarts whenever ce_n is sampled 0.
- R7: After loading ends, the block scans the offsets from 0 to 63, one per clock. Each offset with a set valid flag raises arr_we for one cycle, with arr_addr = {page, offset} and arr_data holding the stored word. Offsets without a set flag give no write.
- R8: The programming period lasts PROG_CYC clocks after the scan. Then busy falls and done rises on the same clock. With GAP_CYC=G and PROG_CYC=P, if no word is loaded, busy falls G+64+P clocks after the clock that accepted start.
- R9: If fail_inject is high on any clock of the scan or the programming period, fail is set when the block finishes, and it stays set.
- R10: While fail is set, start is ignored. clear_fail, given while idle, clears fail.
- R11: arr_we is only ever high while busy is 1 and loading is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse: a program command has been accepted |
| clear_fail | input | 1 | Pulse: clear the recorded failure |
| ce_n | input | 1 | Chip-enable write strobe, active low |
| addr | input | ADDR_W | Word address (page and offset) |
| wdata | input | DATA_W | Word data |
| fail_inject | input | 1 | Model input that makes the programming period fail |
| busy | output | 1 | A load or programming period is in progress |
| loading | output | 1 | Word loads are being accepted |
| done | output | 1 | Last program finished; cleared by the next start |
| fail | output | 1 | A program failure is recorded |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_data | output | DATA_W | Array write data |

## Verification
The bench builds the block with GAP_CYC=40, GLITCH_CYC=3 and PROG_CYC=20. This keeps the inactivity timeout and the programming period to a few dozen cycles, so an exact-cycle check of the timeout and of the busy length fits in one short run. With GLITCH_CYC=3, pulses one cycle long are rejected, while the random low widths of 3 to 5 cycles sit at the acceptance limit and just above it. The gaps between loads stay far enough under 40 cycles that a random load never ends early.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_SCAN = 2'd2,
    ST_WAIT = 2'd3
  } pp_state_t;
endpackage

// File: rtl/pp_ce_sampler.sv
// Detects chip-enable edges, filters short low pulses, captures address/data.
module pp_ce_sampler #(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int GLITCH_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              commit,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);
  localparam int LW_W = $clog2(GLITCH_CYC + 1) + 1;
  localparam logic [LW_W-1:0] LW_MAX = LW_W'(GLITCH_CYC);

  logic            ce_prev;
  logic [LW_W-1:0] low_cnt;
  logic            fall_now;
  logic            rise_now;

  assign fall_now = ce_prev & ~ce_n;
  assign rise_now = ~ce_prev & ce_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_prev <= 1'b1;
      low_cnt <= '0;
      commit  <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      ce_prev <= ce_n;
      commit  <= 1'b0;
      if (fall_now) begin
        addr_q  <= addr_in;
        low_cnt <= LW_W'(1);
      end else if (!ce_n && low_cnt < LW_MAX) begin
        low_cnt <= low_cnt + LW_W'(1);
      end
      if (rise_now) begin
        data_q <= data_in;
        commit <= (low_cnt >= LW_MAX);
      end
    end
  end
endmodule

// File: rtl/pp_gap_timer.sv
// Counts consecutive idle (ce_n high) cycles during loading.
module pp_gap_timer #(
  parameter int GAP_CYC = 12500
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(GAP_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(GAP_CYC - 1);

  logic [CW-1:0] cnt;

  assign expire = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/pp_word_buffer.sv
// Page word store (block-RAM style) plus per-word valid flags.
module pp_word_buffer #(
  parameter int DATA_W = 16,
  parameter int WORDS  = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flag_clear,
  input  logic                     we,
  input  logic [$clog2(WORDS)-1:0] waddr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [$clog2(WORDS)-1:0] raddr,
  output logic [DATA_W-1:0]        rdata,
  output logic [WORDS-1:0]         valid
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst || flag_clear) valid <= '0;
    else if (we) valid[waddr] <= 1'b1;
  end
endmodule

// File: rtl/page_prog_ctrl.sv
module page_prog_ctrl #(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int WORDS      = 64,
  parameter int GAP_CYC    = 12500,
  parameter int GLITCH_CYC = 2,
  parameter int PROG_CYC   = 112500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              clear_fail,
  input  logic              ce_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              fail_inject,
  output logic              busy,
  output logic              loading,
  output logic              done,
  output logic              fail,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data
);
  import pp_pkg::*;

  localparam int WORD_W = $clog2(WORDS);
  localparam int PAGE_W = ADDR_W - WORD_W;
  localparam int PC_W   = $clog2(PROG_CYC + 1);
  localparam logic [WORD_W-1:0] IDX_LAST = WORD_W'(WORDS - 1);
  localparam logic [PC_W-1:0]   PC_LAST  = PC_W'(PROG_CYC - 1);

  pp_state_t         state;
  logic [PAGE_W-1:0] page_q;
  logic              page_set;
  logic [WORD_W-1:0] idx;
  logic [PC_W-1:0]   pcnt;
  logic              fail_acc;

  logic              commit;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  logic              gap_expire;
  logic              start_ok;
  logic              buf_we;
  logic [WORDS-1:0]  valid;

  pp_ce_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GLITCH_CYC(GLITCH_CYC)) u_ce (
    .clk(clk), .rst(rst), .ce_n(ce_n), .addr_in(addr), .data_in(wdata),
    .commit(commit), .addr_q(cap_addr), .data_q(cap_data)
  );

  pp_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk(clk), .rst(rst), .run(loading & ce_n), .expire(gap_expire)
  );

  assign start_ok = start && (state == ST_IDLE) && !fail;
  assign buf_we   = (state == ST_LOAD) && commit &&
                    (!page_set || cap_addr[ADDR_W-1:WORD_W] == page_q);

  pp_word_buffer #(.DATA_W(DATA_W), .WORDS(WORDS)) u_buf (
    .clk(clk), .rst(rst), .flag_clear(start_ok),
    .we(buf_we), .waddr(cap_addr[WORD_W-1:0]), .wdata(cap_data),
    .raddr(idx), .rdata(arr_data), .valid(valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      page_q   <= '0;
      page_set <= 1'b0;
      idx      <= '0;
      pcnt     <= '0;
      fail_acc <= 1'b0;
      busy     <= 1'b0;
      loading  <= 1'b0;
      done     <= 1'b0;
      fail     <= 1'b0;
      arr_we   <= 1'b0;
      arr_addr <= '0;
    end else begin
      arr_we   <= (state == ST_SCAN) && valid[idx];
      arr_addr <= {page_q, idx};
      if (buf_we && !page_set) begin
        page_q   <= cap_addr[ADDR_W-1:WORD_W];
        page_set <= 1'b1;
      end
      if ((state == ST_SCAN || state == ST_WAIT) && fail_inject) fail_acc <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (clear_fail) fail <= 1'b0;
          if (start_ok) begin
            state    <= ST_LOAD;
            busy     <= 1'b1;
            loading  <= 1'b1;
            done     <= 1'b0;
            page_set <= 1'b0;
            fail_acc <= 1'b0;
          end
        end
        ST_LOAD: begin
          if (gap_expire) begin
            state   <= ST_SCAN;
            loading <= 1'b0;
            idx     <= '0;
          end
        end
        ST_SCAN: begin
          if (idx == IDX_LAST) begin
            state <= ST_WAIT;
            pcnt  <= '0;
          end else begin
            idx <= idx + WORD_W'(1);
          end
        end
        ST_WAIT: begin
          if (pcnt == PC_LAST) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
            fail  <= fail | fail_acc | fail_inject;
          end else begin
            pcnt <= pcnt + PC_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pp_ctrl_checker.sv
module pp_ctrl_checker #(
  parameter int ADDR_W = 20,
  parameter int WORDS  = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              loading,
  input logic              done,
  input logic              fail,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr
);
  localparam int WORD_W = $clog2(WORDS);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!busy && !loading && !done && !fail && !arr_we));

  assert_start_loads_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !fail) |=> (loading && busy && !done));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_fail_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && fail) |=> !loading);

  assert_fail_from_run_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> $past(busy));

  assert_we_window_R11: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> (busy && !loading));

  assert_page_steady_R5: assert property (@(posedge clk) disable iff (rst)
    (arr_we && $past(arr_we)) |->
      (arr_addr[ADDR_W-1:WORD_W] == $past(arr_addr[ADDR_W-1:WORD_W])));
endmodule

bind page_prog_ctrl pp_ctrl_checker #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .loading(loading),
  .done(done), .fail(fail), .arr_we(arr_we), .arr_addr(arr_addr)
);

// File: tb/tb_page_prog_ctrl.sv
module tb_page_prog_ctrl;
  localparam int AW = 20, DW = 16, GAP = 40, GL = 3, PROG = 20;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, clear_fail = 1'b0, ce_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic fail_inject = 1'b0;
  logic busy, loading, done, fail, arr_we;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_data;

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;

  logic [AW-1:0] cap_a [128];
  logic [DW-1:0] cap_d [128];
  int cap_n = 0;
  logic [DW-1:0] exp_d [64];
  bit exp_v [64];

  always #4 clk = ~clk;

  page_prog_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WORDS(64), .GAP_CYC(GAP),
                   .GLITCH_CYC(GL), .PROG_CYC(PROG)) dut (
    .clk(clk), .rst(rst), .start(start), .clear_fail(clear_fail), .ce_n(ce_n),
    .addr(addr), .wdata(wdata), .fail_inject(fail_inject), .busy(busy),
    .loading(loading), .done(done), .fail(fail), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_data(arr_data));

  always @(negedge clk) if (arr_we && cap_n < 128) begin
    cap_a[cap_n] = arr_addr; cap_d[cap_n] = arr_data; cap_n++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !finished) begin
      failures++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // low for 'lo' sampled cycles, then high for 'hi' cycles; addr scrambled after capture
  task automatic load_word(input logic [AW-1:0] a, input logic [DW-1:0] d, input int lo, input int hi);
    addr = a; wdata = ~d; ce_n = 1'b0;
    @(negedge clk); addr = ~a;
    cycles(lo - 1);
    wdata = d; ce_n = 1'b1;
    cycles(hi);
  endtask

  task automatic clear_model();
    for (int i = 0; i < 64; i++) begin exp_v[i] = 0; exp_d[i] = '0; end
    cap_n = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
  endtask

  task automatic compare(input logic [13:0] pg, input string tag);
    int k = 0;
    for (int o = 0; o < 64; o++) if (exp_v[o]) begin
      if (k < cap_n) begin
        chk(cap_a[k] == {pg, 6'(o)}, {tag, " addr"}, 32'(cap_a[k]), 32'({pg, 6'(o)}));
        chk(cap_d[k] == exp_d[o], {tag, " data"}, 32'(cap_d[k]), 32'(exp_d[o]));
      end
      k++;
    end
    chk(cap_n == k, {tag, " write count"}, 32'(cap_n), 32'(k));
  endtask

  initial begin
    logic [13:0] pg;
    int g;
    void'($urandom(32'd2024));
    cycles(3); rst = 1'b0; @(negedge clk);
    // R1 reset state
    chk(!busy && !loading && !done && !fail && !arr_we, "R1 reset outputs", {busy, loading, done, fail, arr_we}, 0);

    // R2 start
    clear_model();
    do_start();
    chk(loading && busy && !done, "R2 start -> loading", {loading, busy, done}, 3'b110);

    // R3 R4 R5 random load of one page
    pg = 14'($urandom);
    g = int'($urandom % 64);
    for (int n = 0; n < 14; n++) begin
      int o = int'($urandom % 64);
      logic [DW-1:0] d = DW'($urandom);
      if (o == g) o = (g + 1) % 64;
      if (n == 4) load_word({pg, 6'(g)}, 16'hDEAD, 1, 2);          // R3 glitch, ignored
      if (n == 7) load_word({~pg, 6'(g)}, 16'hBEEF, GL, 2);        // R5 foreign page, ignored
      if (n == 9 && n > 0) begin                                   // R4 same offset twice
        load_word({pg, 6'(o)}, ~d, GL, 2);
      end
      load_word({pg, 6'(o)}, d, GL + int'($urandom % 3), 1 + int'($urandom % 4));
      exp_v[o] = 1; exp_d[o] = d;
    end
    // R6 timeout: ce_n has been high since the last rise edge
    cycles(GAP - 8);
    chk(loading == 1'b1, "R6 still loading before gap", 32'(loading), 1);
    cycles(12);
    chk(loading == 1'b0, "R6 loading ended after gap", 32'(loading), 0);
    wait_idle();
    compare(pg, "R4 R7 random page");
    chk(done && !fail, "R8 done without fail", {done, fail}, 2'b10);

    // R2 flags cleared, R9 fail injection, boundary offsets 63 then 0
    clear_model();
    do_start();
    pg = 14'($urandom);
    load_word({pg, 6'd63}, 16'h1234, GL, 3);
    load_word({pg, 6'd0}, 16'hA5A5, GL + 2, 3);
    exp_v[63] = 1; exp_d[63] = 16'h1234; exp_v[0] = 1; exp_d[0] = 16'hA5A5;
    fail_inject = 1'b1;
    wait_idle();
    fail_inject = 1'b0;
    compare(pg, "R2 R7 second page, old flags gone");
    chk(done && fail, "R9 fail recorded", {done, fail}, 2'b11);

    // R10 start blocked while fail set
    do_start();
    cycles(2);
    chk(!loading && !busy && done, "R10 start ignored with fail", {loading, busy, done}, 3'b001);
    @(negedge clk); clear_fail = 1'b1; @(negedge clk); clear_fail = 1'b0;
    chk(fail == 1'b0, "R10 clear_fail", 32'(fail), 0);
    chk(done == 1'b1, "R10 done kept while idle", 32'(done), 1);

    // R6 R8 exact timing with an empty page
    clear_model();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cycles(GAP - 1);
    chk(loading == 1'b1, "R6 exact: loading at GAP-1", 32'(loading), 1);
    @(negedge clk);
    chk(loading == 1'b0, "R6 exact: loading ends at GAP", 32'(loading), 0);
    cycles(64 + PROG - 1);
    chk(busy == 1'b1 && !done, "R8 exact: busy before end", {busy, done}, 2'b10);
    @(negedge clk);
    chk(!busy && done && !fail, "R8 exact: finish", {busy, done, fail}, 3'b010);
    chk(cap_n == 0, "R7 empty page writes nothing", 32'(cap_n), 0);

    // R3 only a glitch during a load
    clear_model();
    do_start();
    load_word(20'h00ABC, 16'h7777, GL - 1, 3);
    wait_idle();
    chk(cap_n == 0, "R3 short pulse not loaded", 32'(cap_n), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule